// File: doc/BRIEF.md
# DLL Re-enable Sequencer with Frequency Change

This block sits on the controller side of a DDR3 interface. It moves a memory device from DLL-off to DLL-on operation and changes the interface clock frequency in between. It issues a self-refresh bracket, asks an external clock manager to retune the clock, then exits self-refresh. After that it enables the DLL through MR1, resets it through MR0, and reloads MR2 and MR0 with values for the new frequency. A long ZQ calibration can follow if one is wanted.

Each timing limit is a cycle count on an input port. The counts are captured when the start request is accepted. Two status outputs are kept separate. `ready` marks the end of the command sequence. `dllLocked` marks the end of the DLL lock time, and commands that need a locked DLL must wait for it. CKE is held high from self-refresh exit until lock. ODT is pinned low until lock whenever termination was enabled at start.

Top module: `dll_reenable_seq`

## Requirements
- R1: After reset: `cmd` = NOP, `cke` = 1, `freqReq` = 0, `ready` = 1 and `dllLocked` = 0.
- R2: A start is accepted only when all of these hold at a clock edge:
  - `startReq` is high;
  - `ready` is high;
  - `devIdle` is high;
  - no DLL lock timer is running.

  SRE appears on `cmd` in the cycle after the accepting edge. A start request at any other time has no effect.
- R3: Command codes on `cmd` are NOP=0, SRE=1, SRX=2, MRS=3 and ZQCL=4. Each sequence command lasts exactly one cycle. Every other cycle carries NOP.
- R4: Each gap is the larger of its timing count N and 2 cycles, measured between the two events it separates. N is captured at acceptance, and later changes on the timing inputs have no effect on a sequence already running.
- R5: `freqReq` rises the larger of `tCksre` and 2 cycles after SRE, and stays high until the cycle in which `freqAck` is seen. SRX follows the larger of `tCksrx` and 2 cycles after that acknowledge cycle.
- R6: `cke` is 0 from the SRE cycle through the cycle before SRX, and 1 in every other cycle.
- R7: The first MRS comes the larger of `tXs` and 2 cycles after SRX. It uses bank 1 with address `mr1Val`, bit 0 forced to 0 (DLL enable).
- R8: The second MRS comes the larger of `tMrd` and 2 cycles later. It uses bank 0 with address `mr0Val`, bit 8 forced to 1 (DLL reset).
- R9: Two reload writes follow, each the larger of `tMrd` and 2 cycles after the one before:
  - bank 2 with `mr2Val`;
  - then bank 0 with `mr0Val`, bit 8 forced to 0.
- R10: `dllLocked` falls in the SRE cycle of an accepted start. It rises the larger of `tDllk` and 2 cycles after the DLL-reset MRS.
- R11: With `zqOn` captured high, ZQCL (address bit 10 set, all other address bits 0) comes the larger of `tMod` and 2 cycles after the last MRS. `ready` then rises the larger of `tZqoper` and 2 cycles after ZQCL. With `zqOn` low, `ready` rises the larger of `tMod` and 2 cycles after the last MRS.
- R12: If `rttOn` was high at acceptance, `odt` is 0 from the SRE cycle until `dllLocked` rises. At all other times `odt` follows `odtIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to run the sequence |
| devIdle | input | 1 | Device idle: banks precharged, timings met, termination off |
| rttOn | input | 1 | Some termination feature is enabled in the mode registers |
| zqOn | input | 1 | Append a long ZQ calibration |
| odtIn | input | 1 | ODT level wanted by normal traffic |
| freqAck | input | 1 | Clock manager finished the frequency change |
| tCksre | input | 16 | Cycles from SRE to frequency request |
| tCksrx | input | 16 | Cycles of stable clock before SRX |
| tXs | input | 16 | Cycles from SRX to first MRS |
| tMrd | input | 16 | Cycles between MRS commands |
| tMod | input | 16 | Cycles from last MRS to ZQCL or ready |
| tDllk | input | 16 | DLL lock cycles after DLL reset |
| tZqoper | input | 16 | Cycles from ZQCL to ready |
| mr0Val | input | 14 | MR0 value for the new frequency |
| mr1Val | input | 14 | MR1 value for the new frequency |
| mr2Val | input | 14 | MR2 value for the new frequency |
| cmd | output | 3 | Command code |
| cmdBank | output | 3 | Bank address (mode register select) |
| cmdAddr | output | 14 | Address bus |
| cke | output | 1 | Clock enable |
| odt | output | 1 | On-die termination control |
| freqReq | output | 1 | Request for a clock frequency change |
| ready | output | 1 | Sequence finished; general commands allowed |
| dllLocked | output | 1 | DLL lock time has elapsed |

## Verification
The bench builds the block with its default parameters: 16-bit counters and a 14-bit address. This leaves room for a lock time long enough that `ready` rises before `dllLocked`, so a start request can be tried while the lock timer is still running. The stimulus includes counts of 0 and 1 to reach the two-cycle floor. It also varies the acknowledge delay, both termination settings and both calibration settings. The timing inputs are scrambled right after acceptance to show that the captured values govern the run.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_SRE  = 3'd1,
    CMD_SRX  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_ZQCL = 3'd4
  } cmd_e;

  // Index into the captured timing counts
  typedef enum logic [2:0] {
    T_CKSRE = 3'd0,
    T_CKSRX = 3'd1,
    T_XS    = 3'd2,
    T_MRD   = 3'd3,
    T_MOD   = 3'd4,
    T_ZQOP  = 3'd5,
    T_DLLK  = 3'd6
  } tSel_e;

  localparam int NUM_T = 7;

  // Which mode-register write is being issued
  typedef enum logic [1:0] {
    MR_DLL_ON  = 2'd0,
    MR_DLL_RST = 2'd1,
    MR_CWL     = 2'd2,
    MR_CL      = 2'd3
  } mrSel_e;

  typedef struct packed {
    logic   latch;
    logic   loadWait;
    tSel_e  waitSel;
    logic   startDll;
    cmd_e   cmd;
    mrSel_e mrSel;
    logic   ckeLow;
  } ctrlStrobe_t;

endpackage

// File: rtl/dllseq_ctrl.sv
module dllseq_ctrl
  import dllseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        devIdle,
  input  logic        freqAck,
  input  logic        waitDone,
  input  logic        dllPending,
  input  logic        zqLat,
  output ctrlStrobe_t stb,
  output logic        freqReq,
  output logic        ready
);

  typedef enum logic [4:0] {
    S_IDLE, S_SRE, S_WSRE, S_FREQ, S_WCKSRX, S_SRX, S_WXS,
    S_MR1, S_WMR1, S_MR0R, S_WMR0R, S_MR2, S_WMR2, S_MR0L,
    S_WMOD, S_ZQ, S_WZQ
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    stb          = '0;
    stb.cmd      = CMD_NOP;
    stb.waitSel  = T_CKSRE;
    stb.mrSel    = MR_DLL_ON;
    freqReq      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startReq && devIdle && !dllPending) begin
          stb.latch = 1'b1;
          nextState = S_SRE;
        end
      end
      S_SRE: begin
        stb.cmd      = CMD_SRE;
        stb.ckeLow   = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = T_CKSRE;
        nextState    = S_WSRE;
      end
      S_WSRE: begin
        stb.ckeLow = 1'b1;
        if (waitDone) nextState = S_FREQ;
      end
      S_FREQ: begin
        stb.ckeLow = 1'b1;
        freqReq    = 1'b1;
        if (freqAck) begin
          stb.loadWait = 1'b1;
          stb.waitSel  = T_CKSRX;
          nextState    = S_WCKSRX;
        end
      end
      S_WCKSRX: begin
        stb.ckeLow = 1'b1;
        if (waitDone) nextState = S_SRX;
      end
      S_SRX: begin
        stb.cmd      = CMD_SRX;
        stb.loadWait = 1'b1;
        stb.waitSel  = T_XS;
        nextState    = S_WXS;
      end
      S_WXS:   if (waitDone) nextState = S_MR1;
      S_MR1: begin
        stb.cmd      = CMD_MRS;
        stb.mrSel    = MR_DLL_ON;
        stb.loadWait = 1'b1;
        stb.waitSel  = T_MRD;
        nextState    = S_WMR1;
      end
      S_WMR1:  if (waitDone) nextState = S_MR0R;
      S_MR0R: begin
        stb.cmd      = CMD_MRS;
        stb.mrSel    = MR_DLL_RST;
        stb.startDll = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = T_MRD;
        nextState    = S_WMR0R;
      end
      S_WMR0R: if (waitDone) nextState = S_MR2;
      S_MR2: begin
        stb.cmd      = CMD_MRS;
        stb.mrSel    = MR_CWL;
        stb.loadWait = 1'b1;
        stb.waitSel  = T_MRD;
        nextState    = S_WMR2;
      end
      S_WMR2:  if (waitDone) nextState = S_MR0L;
      S_MR0L: begin
        stb.cmd      = CMD_MRS;
        stb.mrSel    = MR_CL;
        stb.loadWait = 1'b1;
        stb.waitSel  = T_MOD;
        nextState    = S_WMOD;
      end
      S_WMOD:  if (waitDone) nextState = zqLat ? S_ZQ : S_IDLE;
      S_ZQ: begin
        stb.cmd      = CMD_ZQCL;
        stb.loadWait = 1'b1;
        stb.waitSel  = T_ZQOP;
        nextState    = S_WZQ;
      end
      S_WZQ:   if (waitDone) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign ready = (state == S_IDLE);

endmodule

// File: rtl/dllseq_datapath.sv
module dllseq_datapath
  import dllseq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              rttOn,
  input  logic              zqOn,
  input  logic              odtIn,
  input  logic [CNT_W-1:0]  tCksre,
  input  logic [CNT_W-1:0]  tCksrx,
  input  logic [CNT_W-1:0]  tXs,
  input  logic [CNT_W-1:0]  tMrd,
  input  logic [CNT_W-1:0]  tMod,
  input  logic [CNT_W-1:0]  tDllk,
  input  logic [CNT_W-1:0]  tZqoper,
  input  logic [ADDR_W-1:0] mr0Val,
  input  logic [ADDR_W-1:0] mr1Val,
  input  logic [ADDR_W-1:0] mr2Val,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cke,
  output logic              odt,
  output logic              dllLocked,
  output logic              waitDone,
  output logic              dllPending,
  output logic              zqLat
);

  localparam int DLL_EN_BIT  = 0;
  localparam int DLL_RST_BIT = 8;
  localparam int ZQ_LONG_BIT = 10;
  localparam logic [BANK_W-1:0] BANK_MR0 = BANK_W'(0);
  localparam logic [BANK_W-1:0] BANK_MR1 = BANK_W'(1);
  localparam logic [BANK_W-1:0] BANK_MR2 = BANK_W'(2);

  function automatic logic [CNT_W-1:0] lessOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [CNT_W-1:0]  tIn  [NUM_T];
  logic [CNT_W-1:0]  tLat [NUM_T];
  logic [ADDR_W-1:0] mr0Lat, mr1Lat, mr2Lat;
  logic [CNT_W-1:0]  waitCnt, dllCnt;
  logic              rttLat, odtHold;

  assign tIn[T_CKSRE] = tCksre;
  assign tIn[T_CKSRX] = tCksrx;
  assign tIn[T_XS]    = tXs;
  assign tIn[T_MRD]   = tMrd;
  assign tIn[T_MOD]   = tMod;
  assign tIn[T_ZQOP]  = tZqoper;
  assign tIn[T_DLLK]  = tDllk;

  // Capture of run parameters at acceptance
  for (genvar g = 0; g < NUM_T; g++) begin : g_tlat
    always_ff @(posedge clk) begin
      if (!rstN)          tLat[g] <= '0;
      else if (stb.latch) tLat[g] <= tIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mr0Lat <= '0;
      mr1Lat <= '0;
      mr2Lat <= '0;
      rttLat <= 1'b0;
      zqLat  <= 1'b0;
    end else if (stb.latch) begin
      mr0Lat <= mr0Val;
      mr1Lat <= mr1Val;
      mr2Lat <= mr2Val;
      rttLat <= rttOn;
      zqLat  <= zqOn;
    end
  end

  // Shared wait counter for the command spacing
  always_ff @(posedge clk) begin
    if (!rstN)                waitCnt <= '0;
    else if (stb.loadWait)    waitCnt <= lessOne(tLat[stb.waitSel]);
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt <= CNT_W'(1));

  // Independent DLL lock timer
  logic dllExpire;
  assign dllExpire = dllPending && (dllCnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dllCnt     <= '0;
      dllPending <= 1'b0;
      dllLocked  <= 1'b0;
      odtHold    <= 1'b0;
    end else if (stb.latch) begin
      dllPending <= 1'b0;
      dllLocked  <= 1'b0;
      odtHold    <= rttOn;
    end else if (stb.startDll) begin
      dllCnt     <= lessOne(tLat[T_DLLK]);
      dllPending <= 1'b1;
    end else if (dllExpire) begin
      dllPending <= 1'b0;
      dllLocked  <= 1'b1;
      odtHold    <= 1'b0;
    end else if (dllPending) begin
      dllCnt     <= dllCnt - 1'b1;
    end
  end

  // Command bus decode
  always_comb begin
    cmd     = stb.cmd;
    cmdBank = '0;
    cmdAddr = '0;
    unique case (stb.cmd)
      CMD_MRS: begin
        unique case (stb.mrSel)
          MR_DLL_ON: begin
            cmdBank = BANK_MR1;
            cmdAddr = mr1Lat;
            cmdAddr[DLL_EN_BIT] = 1'b0;
          end
          MR_DLL_RST: begin
            cmdBank = BANK_MR0;
            cmdAddr = mr0Lat;
            cmdAddr[DLL_RST_BIT] = 1'b1;
          end
          MR_CWL: begin
            cmdBank = BANK_MR2;
            cmdAddr = mr2Lat;
          end
          default: begin
            cmdBank = BANK_MR0;
            cmdAddr = mr0Lat;
            cmdAddr[DLL_RST_BIT] = 1'b0;
          end
        endcase
      end
      CMD_ZQCL: cmdAddr[ZQ_LONG_BIT] = 1'b1;
      default:  ;
    endcase
  end

  assign cke = ~stb.ckeLow;
  assign odt = odtIn & ~(odtHold & rttLat);

endmodule

// File: rtl/dll_reenable_seq.sv
module dll_reenable_seq
  import dllseq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              devIdle,
  input  logic              rttOn,
  input  logic              zqOn,
  input  logic              odtIn,
  input  logic              freqAck,
  input  logic [CNT_W-1:0]  tCksre,
  input  logic [CNT_W-1:0]  tCksrx,
  input  logic [CNT_W-1:0]  tXs,
  input  logic [CNT_W-1:0]  tMrd,
  input  logic [CNT_W-1:0]  tMod,
  input  logic [CNT_W-1:0]  tDllk,
  input  logic [CNT_W-1:0]  tZqoper,
  input  logic [ADDR_W-1:0] mr0Val,
  input  logic [ADDR_W-1:0] mr1Val,
  input  logic [ADDR_W-1:0] mr2Val,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cke,
  output logic              odt,
  output logic              freqReq,
  output logic              ready,
  output logic              dllLocked
);

  ctrlStrobe_t stb;
  logic waitDone, dllPending, zqLat;

  dllseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .devIdle    (devIdle),
    .freqAck    (freqAck),
    .waitDone   (waitDone),
    .dllPending (dllPending),
    .zqLat      (zqLat),
    .stb        (stb),
    .freqReq    (freqReq),
    .ready      (ready)
  );

  dllseq_datapath #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rttOn      (rttOn),
    .zqOn       (zqOn),
    .odtIn      (odtIn),
    .tCksre     (tCksre),
    .tCksrx     (tCksrx),
    .tXs        (tXs),
    .tMrd       (tMrd),
    .tMod       (tMod),
    .tDllk      (tDllk),
    .tZqoper    (tZqoper),
    .mr0Val     (mr0Val),
    .mr1Val     (mr1Val),
    .mr2Val     (mr2Val),
    .cmd        (cmd),
    .cmdBank    (cmdBank),
    .cmdAddr    (cmdAddr),
    .cke        (cke),
    .odt        (odt),
    .dllLocked  (dllLocked),
    .waitDone   (waitDone),
    .dllPending (dllPending),
    .zqLat      (zqLat)
  );

endmodule

// File: rtl/dllseq_checker.sv
module dllseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cmd,
  input logic       cke,
  input logic       freqReq,
  input logic       freqAck,
  input logic       ready,
  input logic       dllLocked
);

  localparam logic [2:0] C_NOP  = 3'd0;
  localparam logic [2:0] C_SRE  = 3'd1;
  localparam logic [2:0] C_SRX  = 3'd2;
  localparam logic [2:0] C_MRS  = 3'd3;
  localparam logic [2:0] C_ZQCL = 3'd4;

  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != C_NOP) |=> (cmd == C_NOP));

  assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cmd == C_NOP && !freqReq));

  assert_freq_in_sr_R5: assert property (@(posedge clk) disable iff (!rstN)
    freqReq |-> !cke);

  assert_freq_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (freqReq && !freqAck) |=> freqReq);

  assert_sre_cke_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == C_SRE) |-> !cke);

  assert_cke_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == C_SRX || cmd == C_MRS || cmd == C_ZQCL) |-> cke);

  assert_lock_cke_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dllLocked) |-> (cke && !freqReq));

endmodule

bind dll_reenable_seq dllseq_checker u_dllseq_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cmd       (cmd),
  .cke       (cke),
  .freqReq   (freqReq),
  .freqAck   (freqAck),
  .ready     (ready),
  .dllLocked (dllLocked)
);

// File: tb/test_dll_reenable_seq.sv
module test_dll_reenable_seq;

  localparam int CW = 16;
  localparam int AW = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, startReq, devIdle, rttOn, zqOn, odtIn, freqAck;
  logic [CW-1:0] tCksre, tCksrx, tXs, tMrd, tMod, tDllk, tZqoper;
  logic [AW-1:0] mr0Val, mr1Val, mr2Val;
  logic [2:0]    cmd, cmdBank;
  logic [AW-1:0] cmdAddr;
  logic cke, odt, freqReq, ready, dllLocked;

  dll_reenable_seq i_dll_reenable_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .devIdle(devIdle),
    .rttOn(rttOn), .zqOn(zqOn), .odtIn(odtIn), .freqAck(freqAck),
    .tCksre(tCksre), .tCksrx(tCksrx), .tXs(tXs), .tMrd(tMrd), .tMod(tMod),
    .tDllk(tDllk), .tZqoper(tZqoper), .mr0Val(mr0Val), .mr1Val(mr1Val),
    .mr2Val(mr2Val), .cmd(cmd), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .cke(cke), .odt(odt), .freqReq(freqReq), .ready(ready),
    .dllLocked(dllLocked)
  );

  typedef struct packed {
    logic [15:0] cksre, cksrx, xs, mrd, mod, dllk, zqop, ackDly;
    logic        rtt, zq;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd5, 16'd6, 16'd10, 16'd4, 16'd12, 16'd40,  16'd20, 16'd3, 1'b1, 1'b1},
    '{16'd0, 16'd1, 16'd2,  16'd2, 16'd1,  16'd0,   16'd0,  16'd0, 1'b0, 1'b0},
    '{16'd2, 16'd2, 16'd3,  16'd3, 16'd3,  16'd3,   16'd3,  16'd7, 1'b1, 1'b0},
    '{16'd7, 16'd3, 16'd20, 16'd5, 16'd6,  16'd100, 16'd9,  16'd1, 1'b0, 1'b1},
    '{16'd1, 16'd9, 16'd4,  16'd2, 16'd15, 16'd2,   16'd50, 16'd0, 1'b1, 1'b1}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gap(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  task automatic runVec(input vec_t v, input int idx);
    int tSre = -1, tReq = -1, tAck = -1, tSrx = -1, tZq = -1;
    int tReady = -1, tLock = -1, nMrs = 0, nCmd = 0, nSre = 0, post = 0;
    int mrsT [4];
    logic [2:0]    mrsB [4];
    logic [AW-1:0] mrsA [4];
    logic [AW-1:0] zqA = '0;
    int ckeBad = 0, odtBad = 0, lockAtStart = -1;
    bit pendTried = 0;
    int eReq, eAck, eSrx, eM1, eM2, eM3, eM4, eZq, eReady, eLock;
    logic [AW-1:0] m0, m1, m2;

    m0 = (idx % 2 == 1) ? 14'h0B52 : 14'h0A52;
    m1 = 14'h0047;
    m2 = 14'h0018;
    eReq = gap(int'(v.cksre));
    eAck = eReq + int'(v.ackDly);
    eSrx = eAck + gap(int'(v.cksrx));
    eM1  = eSrx + gap(int'(v.xs));
    eM2  = eM1 + gap(int'(v.mrd));
    eM3  = eM2 + gap(int'(v.mrd));
    eM4  = eM3 + gap(int'(v.mrd));
    eZq  = v.zq ? eM4 + gap(int'(v.mod)) : -1;
    eReady = v.zq ? eZq + gap(int'(v.zqop)) : eM4 + gap(int'(v.mod));
    eLock  = eM2 + gap(int'(v.dllk));
    for (int k = 0; k < 4; k++) begin
      mrsT[k] = -1; mrsB[k] = '0; mrsA[k] = '0;
    end

    @(negedge clk);
    tCksre = v.cksre; tCksrx = v.cksrx; tXs = v.xs; tMrd = v.mrd;
    tMod = v.mod; tDllk = v.dllk; tZqoper = v.zqop;
    rttOn = v.rtt; zqOn = v.zq; devIdle = 1'b1; odtIn = 1'b1;
    mr0Val = m0; mr1Val = m1; mr2Val = m2;
    startReq = 1'b1;

    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      startReq = 1'b0;
      freqAck  = 1'b0;
      if (c == 0) begin
        // R4: scramble the counts after acceptance
        tCksre = 16'd1; tCksrx = 16'd1; tXs = 16'd1; tMrd = 16'd1;
        tMod = 16'd1; tDllk = 16'd1; tZqoper = 16'd1;
        rttOn = ~v.rtt; zqOn = ~v.zq;
        lockAtStart = int'(dllLocked);
      end
      if (cmd != 3'd0) nCmd++;
      if (cmd == 3'd1) begin nSre++; if (tSre < 0) tSre = c; end
      if (cmd == 3'd2 && tSrx < 0) tSrx = c;
      if (cmd == 3'd3 && nMrs < 4) begin
        mrsT[nMrs] = c; mrsB[nMrs] = cmdBank; mrsA[nMrs] = cmdAddr; nMrs++;
      end
      if (cmd == 3'd4 && tZq < 0) begin tZq = c; zqA = cmdAddr; end
      if (freqReq && tReq < 0) tReq = c;
      if (tReq >= 0 && tAck < 0 && c == tReq + int'(v.ackDly)) begin
        freqAck = 1'b1; tAck = c;
      end
      if (cke !== ((c < eSrx) ? 1'b0 : 1'b1)) ckeBad++;
      if (odt !== ((v.rtt && c < eLock) ? 1'b0 : 1'b1)) odtBad++;
      if (ready && c > 0 && tReady < 0) tReady = c;
      if (dllLocked && tLock < 0) tLock = c;
      if (c == 5) startReq = 1'b1;
      if (ready && !dllLocked && c > 0 && !pendTried) begin
        startReq = 1'b1; pendTried = 1;
      end
      if (tReady >= 0 && tLock >= 0) post++;
      if (post > 8) break;
    end
    startReq = 1'b0;
    freqAck  = 1'b0;

    chk(tSre == 0, "R2", "SRE cycle", tSre, 0);
    chk(lockAtStart == 0, "R10", "dllLocked in SRE cycle", lockAtStart, 0);
    chk(nSre == 1, "R2", "SRE count (busy/pending starts ignored)", nSre, 1);
    chk(nCmd == 6 + int'(v.zq), "R3", "non-NOP cycles", nCmd, 6 + int'(v.zq));
    chk(tReq == eReq, "R5", "freqReq rise", tReq, eReq);
    chk(tSrx == eSrx, "R5", "SRX cycle", tSrx, eSrx);
    chk(ckeBad == 0, "R6", "cke mismatching cycles", ckeBad, 0);
    chk(mrsT[0] == eM1, "R7", "MR1 write cycle", mrsT[0], eM1);
    chk(mrsB[0] == 3'd1 && mrsA[0] == (m1 & ~14'h0001), "R7", "MR1 address",
        int'(mrsA[0]), int'(m1 & ~14'h0001));
    chk(mrsT[1] == eM2, "R8", "DLL reset cycle", mrsT[1], eM2);
    chk(mrsB[1] == 3'd0 && mrsA[1] == (m0 | 14'h0100), "R8", "DLL reset address",
        int'(mrsA[1]), int'(m0 | 14'h0100));
    chk(mrsT[2] == eM3 && mrsT[3] == eM4, "R4", "reload spacing", mrsT[3], eM4);
    chk(mrsB[2] == 3'd2 && mrsA[2] == m2, "R9", "MR2 reload", int'(mrsA[2]), int'(m2));
    chk(mrsB[3] == 3'd0 && mrsA[3] == (m0 & ~14'h0100), "R9", "MR0 reload",
        int'(mrsA[3]), int'(m0 & ~14'h0100));
    chk(tZq == eZq, "R11", "ZQCL cycle", tZq, eZq);
    if (v.zq) chk(zqA == 14'h0400, "R11", "ZQCL address", int'(zqA), 14'h0400);
    chk(tReady == eReady, "R11", "ready rise", tReady, eReady);
    chk(tLock == eLock, "R10", "dllLocked rise", tLock, eLock);
    chk(odtBad == 0, "R12", "odt mismatching cycles", odtBad, 0);
  endtask

  initial begin
    rstN = 1'b0; startReq = 1'b0; devIdle = 1'b0; rttOn = 1'b0; zqOn = 1'b0;
    odtIn = 1'b0; freqAck = 1'b0;
    tCksre = '0; tCksrx = '0; tXs = '0; tMrd = '0; tMod = '0; tDllk = '0;
    tZqoper = '0; mr0Val = '0; mr1Val = '0; mr2Val = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(cmd == 3'd0, "R1", "cmd after reset", int'(cmd), 0);
    chk(cke == 1'b1, "R1", "cke after reset", int'(cke), 1);
    chk(freqReq == 1'b0, "R1", "freqReq after reset", int'(freqReq), 0);
    chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    chk(dllLocked == 1'b0, "R1", "dllLocked after reset", int'(dllLocked), 0);

    // R2: start while device not idle is ignored
    tCksre = 16'd3; tCksrx = 16'd3; tXs = 16'd3; tMrd = 16'd3;
    tMod = 16'd3; tDllk = 16'd3; tZqoper = 16'd3;
    devIdle = 1'b0; startReq = 1'b1;
    begin
      int nonNop = 0, notReady = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (cmd != 3'd0 || !cke) nonNop++;
        if (!ready) notReady++;
      end
      chk(nonNop == 0, "R2", "activity with devIdle low", nonNop, 0);
      chk(notReady == 0, "R2", "ready dropped with devIdle low", notReady, 0);
    end
    startReq = 1'b0;

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    summary();
  end

endmodule